// File: doc/BRIEF.md
# Counterless Serial Byte Transmitter

This block sends bytes as asynchronous serial frames: one low start bit, the data bits least significant first, and one high stop bit. The whole frame sits in a single shift register whose lowest bit drives the line. Each shift fills the top of the register with zeros. The block has no bit counter and no sequencing state machine. It knows a frame has finished when the register reaches a fixed marker pattern: a one in the lowest position and zeros everywhere else.

A producer presents a byte with a valid level and holds it until the byte is taken. A separate divider supplies a baud enable pulse one clock wide. All register activity happens on cycles where that pulse is high, so every bit on the line lasts exactly one baud period. When the producer keeps valid asserted, frames leave back to back, and the only gap between them is the single stop bit.

Top module: `counterless_uart_tx`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `tx_line` is 1 and `tx_ready` is 1.
- R2: A byte is accepted on a rising clock edge where `tx_valid`, `tx_ready` and `baud_tick` are all 1. From the next cycle, `tx_line` is 0 (start bit) and `tx_ready` is 0.
- R3: After the start bit, each later baud tick puts the next data bit on `tx_line`. Data bit 0 comes first and bit DATA_W-1 comes last.
- R4: On the baud tick after the last data bit, `tx_line` becomes 1 (stop bit) and `tx_ready` returns to 1 in the same cycle. This holds whatever the data value, including when the top data bit is 1 and when all data bits are 1.
- R5: On a clock edge where `baud_tick` is 0, neither `tx_line` nor `tx_ready` changes.
- R6: While `tx_ready` is 0, the values of `tx_valid` and `tx_data` have no effect on `tx_line` or `tx_ready`.
- R7: While ready, a `tx_valid` without `baud_tick` loads nothing. The line stays high until a tick arrives with valid still high.
- R8: With `tx_valid` held at 1 and a baud tick on every clock, the stop bit lasts exactly one baud period, and a new frame begins every DATA_W+2 ticks.
- R9: Whenever `tx_ready` is 1, `tx_line` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse at the start of each bit period |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Producer holds this high while `tx_data` is pending |
| tx_ready | output | 1 | High when the stop bit is on the line and a new byte may be taken |
| tx_line | output | 1 | Serial output, high when idle |

## Verification
The bench builds the block with the default eight-bit data width. It drives the baud enable at three spacings: every clock, every third clock, and random with roughly one clock in four. Ticking on every clock makes one bit last one cycle. That exposes, in a short run, the exact edge where the stop bit gives way to the next start bit when valid is held. The sparser spacings leave long stretches without a tick. In those stretches the bench checks that the line holds steady, that valid or data changes during a frame have no effect, and that an early valid waits for the next tick.

// File: rtl/uart_txs_pkg.sv
package uart_txs_pkg;

    // Default payload width of one serial frame.
    parameter int unsigned TXS_DATA_W = 8;

    // What the frame register does on a given clock.
    typedef enum logic [1:0] {
        TXS_HOLD  = 2'd0,
        TXS_LOAD  = 2'd1,
        TXS_SHIFT = 2'd2
    } txs_op_e;

    typedef struct packed {
        txs_op_e op;
        logic    accept;
    } txs_ctrl_t;

    // Choose the register operation from the marker match and the inputs.
    function automatic txs_ctrl_t txs_decide(input logic at_marker,
                                             input logic tick,
                                             input logic valid);
        txs_ctrl_t c;
        c.op     = TXS_HOLD;
        c.accept = 1'b0;
        if (tick) begin
            if (!at_marker) begin
                c.op = TXS_SHIFT;
            end else if (valid) begin
                c.op     = TXS_LOAD;
                c.accept = 1'b1;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/txs_framer.sv
module txs_framer #(
    parameter int unsigned DATA_W  = uart_txs_pkg::TXS_DATA_W,
    localparam int unsigned FRAME_W = DATA_W + 2
) (
    input  logic [DATA_W-1:0]  data_i,
    output logic [FRAME_W-1:0] frame_o
);

    // Bit 0 is the start bit, the data follows LSB first, and the top bit is the stop bit.
    assign frame_o[0]         = 1'b0;
    assign frame_o[FRAME_W-1] = 1'b1;

    for (genvar i = 0; i < DATA_W; i++) begin : g_payload
        assign frame_o[i+1] = data_i[i];
    end

endmodule

// File: rtl/txs_marker.sv
module txs_marker #(
    parameter int unsigned FRAME_W = uart_txs_pkg::TXS_DATA_W + 2
) (
    input  logic [FRAME_W-1:0] sr_i,
    output logic               match_o
);

    // Zeros above the lowest bit mean the stop bit has reached the line.
    logic [FRAME_W-2:0] upper_clear;

    for (genvar i = 1; i < FRAME_W; i++) begin : g_upper
        assign upper_clear[i-1] = ~sr_i[i];
    end

    assign match_o = sr_i[0] & (&upper_clear);

endmodule

// File: rtl/txs_shifter.sv
module txs_shifter
    import uart_txs_pkg::*;
#(
    parameter int unsigned FRAME_W = TXS_DATA_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  txs_op_e            op_i,
    input  logic [FRAME_W-1:0] load_i,
    output logic [FRAME_W-1:0] sr_o
);

    localparam logic [FRAME_W-1:0] MARKER = {{(FRAME_W-1){1'b0}}, 1'b1};

    logic [FRAME_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= MARKER;
        end else begin
            case (op_i)
                TXS_LOAD:  sr_q <= load_i;
                TXS_SHIFT: sr_q <= {1'b0, sr_q[FRAME_W-1:1]};
                default:   sr_q <= sr_q;
            endcase
        end
    end

    assign sr_o = sr_q;

    // R4: the single one that marks the frame's end is never shifted away.
    p_marker_kept_r4: assert property (@(posedge clk) disable iff (rst)
        sr_q != '0);

    // R3: a shift adds no new ones to the register.
    p_shift_no_new_ones_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == TXS_SHIFT) |=> ($countones(sr_q) <= $countones($past(sr_q))));

endmodule

// File: rtl/counterless_uart_tx.sv
module counterless_uart_tx
    import uart_txs_pkg::*;
#(
    parameter int unsigned DATA_W = TXS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_line
);

    localparam int unsigned FRAME_W = DATA_W + 2;

    logic [FRAME_W-1:0] frame_w;
    logic [FRAME_W-1:0] sr_w;
    logic               at_marker;
    txs_ctrl_t          ctrl;

    txs_framer #(.DATA_W(DATA_W)) u_framer (
        .data_i  (tx_data),
        .frame_o (frame_w)
    );

    txs_marker #(.FRAME_W(FRAME_W)) u_marker (
        .sr_i    (sr_w),
        .match_o (at_marker)
    );

    always_comb begin
        ctrl = txs_decide(at_marker, baud_tick, tx_valid);
    end

    txs_shifter #(.FRAME_W(FRAME_W)) u_shifter (
        .clk    (clk),
        .rst    (rst),
        .op_i   (ctrl.op),
        .load_i (frame_w),
        .sr_o   (sr_w)
    );

    assign tx_ready = at_marker;
    assign tx_line  = sr_w[0];

    // R1: the block comes out of reset idle and ready.
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_ready && tx_line));

    // R2: an accepted byte puts the start bit on the line at once.
    p_start_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && baud_tick) |=> (!tx_line && !tx_ready));

    // R5: without a tick the outputs hold.
    p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (!baud_tick) |=> ($stable(tx_line) && $stable(tx_ready)));

    // R7: valid alone, without a tick, does not start a frame.
    p_wait_for_tick_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && !baud_tick) |=> tx_ready);

    // R9: ready implies the line is high.
    p_ready_line_high_r9: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> tx_line);

endmodule

// File: tb/counterless_uart_tx_test.sv
module counterless_uart_tx_test;

    localparam int unsigned DW   = 8;
    localparam int unsigned IDLE = DW + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          baud_tick = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          tx_valid = 1'b0;
    logic          tx_ready;
    logic          tx_line;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Bench model: index of the frame bit now on the line (IDLE = stop bit / ready).
    int unsigned   pos = IDLE;
    logic [DW-1:0] mdata = '0;

    always #5 clk = ~clk;

    counterless_uart_tx #(.DATA_W(DW)) uut (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_line   (tx_line)
    );

    function automatic logic exp_line(input int unsigned p, input logic [DW-1:0] d);
        if (p == IDLE) return 1'b1;
        if (p == 0)    return 1'b0;
        return d[p-1];
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b pos=%0d", tag, what, act, exp, pos);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge, sample after it.
    task automatic step(input logic r, input logic t, input logic v, input logic [DW-1:0] d,
                        input string tag_in);
        string tag;
        bit    busy_before;
        @(negedge clk);
        rst = r; baud_tick = t; tx_valid = v; tx_data = d;
        @(posedge clk);
        busy_before = (pos != IDLE);
        if (r) begin
            pos = IDLE;
        end else if (t) begin
            if (pos == IDLE) begin
                if (v) begin pos = 0; mdata = d; end
            end else begin
                pos = pos + 1;
            end
        end
        #2;
        if (tag_in != "")            tag = tag_in;
        else if (!t)                 tag = "R5";
        else if (busy_before && v)   tag = "R6";
        else if (pos == 0)           tag = "R2";
        else if (pos == IDLE)        tag = "R4";
        else                         tag = "R3";
        check(tag, tx_line, exp_line(pos, mdata), "tx_line");
        check((pos == IDLE) ? "R9" : tag, tx_ready, (pos == IDLE), "tx_ready");
    endtask

    task automatic send_frame(input logic [DW-1:0] d, input int unsigned gap);
        step(1'b0, 1'b1, 1'b1, d, "");
        for (int b = 0; b < int'(DW) + 1; b++) begin
            for (int g = 0; g < int'(gap) - 1; g++) step(1'b0, 1'b0, 1'b0, ~d, "");
            step(1'b0, 1'b1, 1'b0, d, "");
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int readies;
        seed = $urandom(32'd2718);

        // R1: reset state, during and right after reset.
        step(1'b1, 1'b0, 1'b0, '0, "R1");
        step(1'b1, 1'b1, 1'b1, 8'h3C, "R1");
        step(1'b0, 1'b0, 1'b0, '0, "R1");

        // R7: valid without tick while idle starts nothing.
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1, 8'h5A, "R7");
        step(1'b0, 1'b1, 1'b1, 8'h5A, "R7");
        for (int b = 0; b < int'(DW) + 1; b++) begin
            step(1'b0, 1'b0, 1'b0, '0, "");
            step(1'b0, 1'b1, 1'b0, '0, "");
        end

        // R3/R4: directed patterns at a spacing of three clocks, with d7 set and all-ones corners.
        send_frame(8'hA5, 3);
        send_frame(8'h80, 3);
        send_frame(8'hFF, 3);
        send_frame(8'h00, 3);
        send_frame(8'h01, 1);

        // R8: valid held, tick every clock: one ready cycle per frame of DW+2 ticks.
        readies = 0;
        for (int i = 0; i < 5 * (int'(DW) + 2); i++) begin
            step(1'b0, 1'b1, 1'b1, 8'(i * 37), "");
            if (tx_ready) readies++;
        end
        checks++;
        if (readies != 5) begin
            fails++;
            $display("FAIL R8 ready cycles actual=%0d expected=%0d", readies, 5);
        end

        // Mixed random traffic: sparse ticks, valid and data toggling mid-frame (R5, R6).
        for (int i = 0; i < 3000; i++) begin
            step(1'b0, ($urandom % 4) == 0, $urandom % 2, 8'($urandom), "");
        end

        // R1: reset in the middle of a frame returns to idle.
        step(1'b0, 1'b1, 1'b1, 8'h00, "");
        step(1'b0, 1'b1, 1'b0, 8'h00, "");
        step(1'b1, 1'b0, 1'b0, 8'h00, "R1");
        step(1'b0, 1'b0, 1'b0, 8'h00, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule